// File: doc/BRIEF.md
# Floppy Drive Phase-Line Status and Command Decoder

This block sits on the drive side of a four-wire phase interface. The controller drives three phase lines and a select line. Together these four bits form a 4-bit code. While the code is held, the block places one status bit on a single sense output. Most status bits are active low: 0 means the condition is true. Some codes also pick which read head is active.

A low-to-high transition on the strobe line turns the same lines into a command. The commands are: latch a step direction, step the head one track, start the motor, and eject the disk. The block keeps the step direction, the current track, the head choice and the motor state. It emits one-cycle step and eject pulses to the mechanism. The disk-present, write-protect, tachometer and two-sided inputs come from the mechanism. The block does not model any mechanical timing.

In this document the code is written as {ph2, ph1, ph0, sel}, with ph2 as the most significant bit.

Top module: `fdd_phase_drive`

## Requirements
- R1: Synchronous reset, active high, sets the following state: stored direction inward (0), track 0, head 0, motor off, and both `step_pulse` and `eject_pulse` low.
- R2: Sense reports the media inputs combinationally:
  - code 0001 gives NOT `disk_present`.
  - code 0011 gives NOT `write_protect`.
  - code 1100 gives NOT `two_sided`.
  - code 0111 gives `tacho` unchanged.
- R3: Sense reports the drive state:
  - code 0000 gives the stored direction (1 = outward, 0 = inward).
  - code 0100 gives NOT `motor_on`.
  - code 0101 gives 0 exactly when the track is 0.
- R4: Code 0010 (step done) senses 1. Code 1110 senses 0. Code 1111 senses 1. Every other unlisted code senses 1: 0110, 1000, 1001, 1010, 1011 and 1101.
- R5: If code 1000 is present at a clock edge, `head_sel` becomes 0 from that edge. If code 1001 is present, `head_sel` becomes 1. Any other code leaves `head_sel` unchanged.
- R6: A strobe rise with {ph1,ph0,sel}=000 loads the stored direction from ph2 (1 = outward), effective from the edge that samples the rise.
- R7: A strobe rise with {ph1,ph0,sel}=010 has these effects:
  - `step_pulse` is high for exactly the one cycle after the edge that samples the rise.
  - `step_outward` equals the stored direction.
  - `track` decrements on an outward step and increments on an inward step.
- R8: `track` saturates at 0 on outward steps and at MAX_TRACK on inward steps. A step pulse is still emitted when the track is saturated.
- R9: A strobe rise with {ph1,ph0,sel}=100 sets `motor_on`. A strobe rise with {ph1,ph0,sel}=110 gives a one-cycle `eject_pulse` and clears `motor_on`.
- R10: Holding the strobe line high issues no further command. Strobe rises with {ph1,ph0,sel} equal to 001, 011, 101 or 111 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ph | input | 3 | Phase lines {ph2,ph1,ph0} |
| sel | input | 1 | Select line, the least significant bit of the code |
| strobe | input | 1 | Command strobe; a rising edge executes a command |
| disk_present | input | 1 | Media is inserted |
| write_protect | input | 1 | Media is write protected |
| tacho | input | 1 | Spindle tachometer signal |
| two_sided | input | 1 | Drive has two heads |
| sense | output | 1 | Status bit selected by the code |
| step_pulse | output | 1 | One-cycle step request |
| step_outward | output | 1 | Direction that goes with `step_pulse` (1 = outward) |
| head_sel | output | 1 | Active read head (0 lower, 1 upper) |
| motor_on | output | 1 | Spindle motor state |
| eject_pulse | output | 1 | One-cycle eject request |
| track | output | $clog2(MAX_TRACK+1) | Current head track |

## Verification
The sense multiplexer is tried with all sixteen codes under one set of media inputs. It is then tried again on the media codes with every media input inverted. This separates a correct decode from a stuck bit or a polarity error, and from two codes being swapped.

The strobe commands are tried several ways:
- inward and outward steps taken from the middle of the track range;
- steps that push against both saturation limits;
- a strobe held high across several edges;
- rises carrying each unlisted sub-code.

Together these tell edge detection apart from level sensing, and ignored codes apart from decoded ones. Head selection is tested by alternating the two head codes and then holding an unrelated code.

// File: rtl/fdd_pkg.sv
package fdd_pkg;

    // Status select codes, written as {ph2, ph1, ph0, sel}
    localparam logic [3:0] SC_DIR     = 4'b0000;
    localparam logic [3:0] SC_DISK    = 4'b0001;
    localparam logic [3:0] SC_DONE    = 4'b0010;
    localparam logic [3:0] SC_WPROT   = 4'b0011;
    localparam logic [3:0] SC_MOTOR   = 4'b0100;
    localparam logic [3:0] SC_TRK0    = 4'b0101;
    localparam logic [3:0] SC_TACH    = 4'b0111;
    localparam logic [3:0] SC_HEAD0   = 4'b1000;
    localparam logic [3:0] SC_HEAD1   = 4'b1001;
    localparam logic [3:0] SC_SIDES   = 4'b1100;
    localparam logic [3:0] SC_PRESENT = 4'b1110;
    localparam logic [3:0] SC_INST    = 4'b1111;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_DIR,
        CMD_STEP,
        CMD_MOTOR,
        CMD_EJECT
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e kind;
        logic      arg;   // ph2 at the time of the strobe
    } cmd_t;

    typedef struct packed {
        logic disk_in;
        logic wprot;
        logic motor;
        logic at_zero;
        logic tacho;
        logic two_sided;
        logic outward;
    } drv_stat_t;

    function automatic cmd_t decode_cmd(input logic [3:0] code);
        cmd_t c;
        c.arg = code[3];
        case (code[2:0])
            3'b000:  c.kind = CMD_DIR;
            3'b010:  c.kind = CMD_STEP;
            3'b100:  c.kind = CMD_MOTOR;
            3'b110:  c.kind = CMD_EJECT;
            default: c.kind = CMD_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fdd_strobe_cmd.sv
module fdd_strobe_cmd
    import fdd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       strobe,
    input  logic [3:0] code,
    output cmd_t       cmd
);

    logic strobe_q;

    always_ff @(posedge clk) begin
        if (rst) strobe_q <= 1'b0;
        else     strobe_q <= strobe;
    end

    always_comb begin
        if (strobe && !strobe_q) cmd = decode_cmd(code);
        else                     cmd = cmd_t'{kind: CMD_NONE, arg: 1'b0};
    end

endmodule

// File: rtl/fdd_mech_state.sv
module fdd_mech_state
    import fdd_pkg::*;
#(
    parameter int MAX_TRACK = 79,
    parameter int TRACK_W   = $clog2(MAX_TRACK + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  cmd_t               cmd,
    input  logic [3:0]         code,
    output logic               outward,
    output logic [TRACK_W-1:0] track,
    output logic               step_pulse,
    output logic               step_outward,
    output logic               head_sel,
    output logic               motor_on,
    output logic               eject_pulse
);

    localparam logic [TRACK_W-1:0] TOP = TRACK_W'(MAX_TRACK);

    always_ff @(posedge clk) begin
        if (rst) begin
            outward      <= 1'b0;
            track        <= '0;
            step_pulse   <= 1'b0;
            step_outward <= 1'b0;
            head_sel     <= 1'b0;
            motor_on     <= 1'b0;
            eject_pulse  <= 1'b0;
        end else begin
            step_pulse  <= 1'b0;
            eject_pulse <= 1'b0;
            if (code == SC_HEAD0)      head_sel <= 1'b0;
            else if (code == SC_HEAD1) head_sel <= 1'b1;
            case (cmd.kind)
                CMD_DIR:   outward <= cmd.arg;
                CMD_STEP: begin
                    step_pulse   <= 1'b1;
                    step_outward <= outward;
                    if (outward) begin
                        if (track != '0) track <= track - 1'b1;
                    end else begin
                        if (track != TOP) track <= track + 1'b1;
                    end
                end
                CMD_MOTOR: motor_on <= 1'b1;
                CMD_EJECT: begin
                    motor_on    <= 1'b0;
                    eject_pulse <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fdd_sense_mux.sv
module fdd_sense_mux
    import fdd_pkg::*;
(
    input  logic [3:0] code,
    input  drv_stat_t  stat,
    output logic       sense
);

    always_comb begin
        case (code)
            SC_DIR:     sense = stat.outward;
            SC_DISK:    sense = !stat.disk_in;
            SC_DONE:    sense = 1'b1;
            SC_WPROT:   sense = !stat.wprot;
            SC_MOTOR:   sense = !stat.motor;
            SC_TRK0:    sense = !stat.at_zero;
            SC_TACH:    sense = stat.tacho;
            SC_SIDES:   sense = !stat.two_sided;
            SC_PRESENT: sense = 1'b0;
            SC_INST:    sense = 1'b1;
            default:    sense = 1'b1;
        endcase
    end

endmodule

// File: rtl/fdd_phase_drive.sv
module fdd_phase_drive
    import fdd_pkg::*;
#(
    parameter int MAX_TRACK = 79,
    parameter int TRACK_W   = $clog2(MAX_TRACK + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         ph,
    input  logic               sel,
    input  logic               strobe,
    input  logic               disk_present,
    input  logic               write_protect,
    input  logic               tacho,
    input  logic               two_sided,
    output logic               sense,
    output logic               step_pulse,
    output logic               step_outward,
    output logic               head_sel,
    output logic               motor_on,
    output logic               eject_pulse,
    output logic [TRACK_W-1:0] track
);

    logic [3:0] code;
    cmd_t       cmd;
    logic       outward;
    drv_stat_t  stat;

    assign code = {ph, sel};

    fdd_strobe_cmd strobe_i (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe),
        .code   (code),
        .cmd    (cmd)
    );

    fdd_mech_state #(
        .MAX_TRACK (MAX_TRACK),
        .TRACK_W   (TRACK_W)
    ) mech_i (
        .clk          (clk),
        .rst          (rst),
        .cmd          (cmd),
        .code         (code),
        .outward      (outward),
        .track        (track),
        .step_pulse   (step_pulse),
        .step_outward (step_outward),
        .head_sel     (head_sel),
        .motor_on     (motor_on),
        .eject_pulse  (eject_pulse)
    );

    always_comb begin
        stat.disk_in   = disk_present;
        stat.wprot     = write_protect;
        stat.motor     = motor_on;
        stat.at_zero   = (track == '0);
        stat.tacho     = tacho;
        stat.two_sided = two_sided;
        stat.outward   = outward;
    end

    fdd_sense_mux sense_i (
        .code  (code),
        .stat  (stat),
        .sense (sense)
    );

endmodule

// File: rtl/fdd_phase_drive_chk.sv
module fdd_phase_drive_chk #(
    parameter int MAX_TRACK = 79,
    parameter int TRACK_W   = $clog2(MAX_TRACK + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic [2:0]         ph,
    input logic               sel,
    input logic               sense,
    input logic               step_pulse,
    input logic               step_outward,
    input logic               head_sel,
    input logic               motor_on,
    input logic               eject_pulse,
    input logic [TRACK_W-1:0] track
);

    localparam logic [TRACK_W-1:0] TOP = TRACK_W'(MAX_TRACK);

    a_r4_done_reads_one: assert property (@(posedge clk) disable iff (rst)
        ({ph, sel} == 4'b0010) |-> sense);

    a_r4_present_reads_zero: assert property (@(posedge clk) disable iff (rst)
        ({ph, sel} == 4'b1110) |-> !sense);

    a_r5_upper_head: assert property (@(posedge clk) disable iff (rst)
        ({ph, sel} == 4'b1001) |=> head_sel);

    a_r5_lower_head: assert property (@(posedge clk) disable iff (rst)
        ({ph, sel} == 4'b1000) |=> !head_sel);

    a_r7_inward_moves: assert property (@(posedge clk) disable iff (rst)
        (step_pulse && !step_outward && $past(track) != TOP)
            |-> track == TRACK_W'($past(track) + 1'b1));

    a_r7_outward_moves: assert property (@(posedge clk) disable iff (rst)
        (step_pulse && step_outward && $past(track) != '0)
            |-> track == TRACK_W'($past(track) - 1'b1));

    a_r8_track_bound: assert property (@(posedge clk) disable iff (rst)
        track <= TOP);

    a_r8_low_hold: assert property (@(posedge clk) disable iff (rst)
        (step_pulse && step_outward && $past(track) == '0) |-> track == '0);

    a_r9_eject_stops_motor: assert property (@(posedge clk) disable iff (rst)
        eject_pulse |-> !motor_on);

    a_r10_single_step: assert property (@(posedge clk) disable iff (rst)
        step_pulse |=> !step_pulse);

endmodule

bind fdd_phase_drive fdd_phase_drive_chk #(
    .MAX_TRACK (MAX_TRACK),
    .TRACK_W   (TRACK_W)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .ph           (ph),
    .sel          (sel),
    .sense        (sense),
    .step_pulse   (step_pulse),
    .step_outward (step_outward),
    .head_sel     (head_sel),
    .motor_on     (motor_on),
    .eject_pulse  (eject_pulse),
    .track        (track)
);

// File: tb/fdd_phase_drive_tb_top.sv
module fdd_phase_drive_tb_top;

    localparam int MAXT = 4;
    localparam int TW   = $clog2(MAXT + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    ph = '0;
    logic          sel = 1'b0;
    logic          strobe = 1'b0;
    logic          disk_present = 1'b0;
    logic          write_protect = 1'b0;
    logic          tacho = 1'b0;
    logic          two_sided = 1'b0;
    logic          sense, step_pulse, step_outward, head_sel, motor_on, eject_pulse;
    logic [TW-1:0] track;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    fdd_phase_drive #(.MAX_TRACK(MAXT)) dut_i (
        .clk(clk), .rst(rst), .ph(ph), .sel(sel), .strobe(strobe),
        .disk_present(disk_present), .write_protect(write_protect),
        .tacho(tacho), .two_sided(two_sided), .sense(sense),
        .step_pulse(step_pulse), .step_outward(step_outward),
        .head_sel(head_sel), .motor_on(motor_on),
        .eject_pulse(eject_pulse), .track(track)
    );

    // {code[3:0], disk_present, write_protect, tacho, two_sided, expected sense}
    // state during the walk: direction inward, motor off, track 0
    localparam logic [8:0] VEC [0:19] = '{
        {4'b0000, 4'b1011, 1'b0}, {4'b0001, 4'b1011, 1'b0},
        {4'b0010, 4'b1011, 1'b1}, {4'b0011, 4'b1011, 1'b1},
        {4'b0100, 4'b1011, 1'b1}, {4'b0101, 4'b1011, 1'b0},
        {4'b0110, 4'b1011, 1'b1}, {4'b0111, 4'b1011, 1'b1},
        {4'b1000, 4'b1011, 1'b1}, {4'b1001, 4'b1011, 1'b1},
        {4'b1010, 4'b1011, 1'b1}, {4'b1011, 4'b1011, 1'b1},
        {4'b1100, 4'b1011, 1'b0}, {4'b1101, 4'b1011, 1'b1},
        {4'b1110, 4'b1011, 1'b0}, {4'b1111, 4'b1011, 1'b1},
        {4'b0001, 4'b0100, 1'b1}, {4'b0011, 4'b0100, 1'b0},
        {4'b0111, 4'b0100, 1'b0}, {4'b1100, 4'b0100, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    // Raise the strobe with a code; returns one edge later, strobe still high
    task automatic strobe_up(input logic [3:0] c);
        {ph, sel} = c;
        strobe = 1'b1;
        tick();
    endtask

    task automatic strobe_down;
        strobe = 1'b0;
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 track", int'(track), 0);
        chk("R1 head", int'(head_sel), 0);
        chk("R1 motor", int'(motor_on), 0);
        chk("R1 step", int'(step_pulse), 0);
        chk("R1 eject", int'(eject_pulse), 0);

        // R2 R3 R4 sense table walk
        for (int i = 0; i < 20; i++) begin
            {ph, sel} = VEC[i][8:5];
            {disk_present, write_protect, tacho, two_sided} = VEC[i][4:1];
            #2;
            chk($sformatf("R2/R3/R4 sense code %b", VEC[i][8:5]), int'(sense), int'(VEC[i][0]));
            tick();
        end

        // R5 head selection
        {ph, sel} = 4'b1001; tick();
        chk("R5 head upper", int'(head_sel), 1);
        {ph, sel} = 4'b1000; tick();
        chk("R5 head lower", int'(head_sel), 0);
        {ph, sel} = 4'b1001; tick();
        {ph, sel} = 4'b0110; tick(); tick();
        chk("R5 head held", int'(head_sel), 1);

        // R7 inward step from 0
        strobe_up(4'b0010);
        chk("R7 step pulse", int'(step_pulse), 1);
        chk("R7 step dir", int'(step_outward), 0);
        chk("R7 track inc", int'(track), 1);
        strobe_down();
        chk("R7 pulse width", int'(step_pulse), 0);

        // R10 strobe held high
        strobe_up(4'b0010);
        chk("R7 track inc 2", int'(track), 2);
        tick(); tick();
        chk("R10 held no pulse", int'(step_pulse), 0);
        chk("R10 held no move", int'(track), 2);
        strobe_down();

        // R6 set outward, observe at code 0000
        strobe_up(4'b1000);
        strobe_down();
        {ph, sel} = 4'b0000; #2;
        chk("R6 dir outward sense", int'(sense), 1);
        {ph, sel} = 4'b0101; #2;
        chk("R3 not track0", int'(sense), 1);

        // R7 outward steps, R8 low saturation
        strobe_up(4'b0010);
        chk("R7 outward dir", int'(step_outward), 1);
        chk("R7 track dec", int'(track), 1);
        strobe_down();
        strobe_up(4'b0010); strobe_down();
        chk("R7 track at 0", int'(track), 0);
        strobe_up(4'b0010);
        chk("R8 low sat pulse", int'(step_pulse), 1);
        chk("R8 low sat track", int'(track), 0);
        strobe_down();

        // R9 motor on, eject
        strobe_up(4'b0100);
        chk("R9 motor on", int'(motor_on), 1);
        strobe_down();
        {ph, sel} = 4'b0100; #2;
        chk("R3 motor sense", int'(sense), 0);
        strobe_up(4'b0110);
        chk("R9 eject pulse", int'(eject_pulse), 1);
        chk("R9 motor off", int'(motor_on), 0);
        strobe_down();
        chk("R9 eject width", int'(eject_pulse), 0);

        // R10 unlisted sub-codes ignored (motor off, outward, track 0)
        strobe_up(4'b0100); strobe_down();   // motor on again
        strobe_up(4'b1001); strobe_down();
        strobe_up(4'b1011); strobe_down();
        strobe_up(4'b1101);
        chk("R10 unlisted no eject", int'(eject_pulse), 0);
        strobe_down();
        strobe_up(4'b0111);
        chk("R10 unlisted no step", int'(step_pulse), 0);
        strobe_down();
        chk("R10 motor kept", int'(motor_on), 1);
        chk("R10 track kept", int'(track), 0);
        {ph, sel} = 4'b0000; #2;
        chk("R10 dir kept", int'(sense), 1);

        // R6 set inward, R8 high saturation
        strobe_up(4'b0000); strobe_down();
        {ph, sel} = 4'b0000; #2;
        chk("R6 dir inward sense", int'(sense), 0);
        for (int k = 0; k < MAXT; k++) begin
            strobe_up(4'b0010); strobe_down();
        end
        chk("R8 reach max", int'(track), MAXT);
        strobe_up(4'b0010);
        chk("R8 high sat pulse", int'(step_pulse), 1);
        chk("R8 high sat track", int'(track), MAXT);
        strobe_down();

        // R1 reset again
        rst = 1'b1; tick(); rst = 1'b0;
        chk("R1 reset track", int'(track), 0);
        chk("R1 reset motor", int'(motor_on), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule